// File: doc/BRIEF.md
# Floating-Point Register NaN-Box Checker

This block sits between a scalar floating-point register file and datapaths that work on narrower formats. On the write side it takes a narrow result and builds the full register value. The result goes in the low bits and every bit above it is set to one. On the read side it takes a full register value and a format select, and returns the operand in that format. An operand counts as valid only when every register bit above the operand width is one. If any of those bits is zero, the block returns the quiet canonical NaN of the requested format.

Every consumer of a scalar floating-point register goes through this check, including the scalar operand of a vector-scalar operation. The read path is purely combinational. The register width is a parameter and must be at least 32. When the register width equals a format's width, that format is passed through without a check. A debug output reports that a substitution took place. It raises no exception flag.

Format select encoding, used on both paths: 2'b00 half-width brain float (16 bits), 2'b01 IEEE half precision (16 bits), 2'b10 IEEE single precision (32 bits), 2'b11 reserved.

Top module: `nanbox_checker`

## Requirements
- R1: For a write with format 2'b00 or 2'b01, `wr_reg[15:0]` equals `wr_result[15:0]` and every bit of `wr_reg` above bit 15 is 1. Bits 31:16 of `wr_result` have no effect.
- R2: For a write with format 2'b10, `wr_reg[31:0]` equals `wr_result` and every bit of `wr_reg` above bit 31 is 1.
- R3: For a read in which every register bit above the operand width is 1, `rd_operand` holds the low register bits unchanged. All of its bits above the operand width are 0, and `rd_box_fault` is 0.
- R4: A 2'b00 read with any zero bit above bit 15 gives `rd_operand` = 0x7fc0 and sets `rd_box_fault` to 1.
- R5: A 2'b01 read with any zero bit above bit 15 gives `rd_operand` = 0x7e00 and sets `rd_box_fault` to 1.
- R6: A 2'b10 read with any zero bit above bit 31, when `REG_W` > 32, gives `rd_operand` = 0x7fc00000 and sets `rd_box_fault` to 1.
- R7: A single zero bit at any position of the upper field is enough to cause the substitution. This includes the bit just above the operand and the register MSB.
- R8: The operand bits themselves never take part in the check. A boxed register whose low bits are all zeros, all ones or a NaN pattern is returned unchanged.
- R9: Format 2'b11 passes data through unchanged. A read returns `rd_reg` with `rd_box_fault` 0, and a write returns `wr_result` zero-extended.
- R10: A value produced by the write path for a format reads back, with the same format, as the original low result bits and no fault.
- R11: When `REG_W` equals 32, a 2'b10 read returns `rd_reg` unchanged with no fault, and a 2'b10 write returns `wr_result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_reg | input | REG_W | Full register value being read |
| rd_fmt | input | 2 | Format of the read operand |
| rd_operand | output | REG_W | Extracted operand, zero-extended, or canonical NaN |
| rd_box_fault | output | 1 | Debug: read operand was not properly boxed |
| wr_fmt | input | 2 | Format of the result being written |
| wr_result | input | 32 | Narrow result; only the low format-width bits are used |
| wr_reg | output | REG_W | Boxed register value to write back |

## Verification
The bench places single zero bits at the edges of the upper field: the bit just above a 16-bit operand, the bit just above a 32-bit operand, and the register MSB. A design that checked only part of the field, or was off by one at its lower end, would let such a value through. Boxed registers carrying all-zero, all-one and NaN-like low bits are included. A design that folded the operand bits into the check would wrongly substitute a NaN for them. The bench uses distinct NaN constants for the two 16-bit formats, so a swapped constant shows up. It also exercises a write-then-read round trip and a second instance with a 32-bit register, in which single precision must pass through with no check.

// File: rtl/nanbox_pkg.sv
// Package: shared format encoding and per-format constants for the
// NaN-box checker. Assumes formats are numbered 0..NB_FMT_N-1 in the
// same order as the select encoding.
package nanbox_pkg;

    typedef enum logic [1:0] {
        FMT_BF16 = 2'b00,
        FMT_FP16 = 2'b01,
        FMT_FP32 = 2'b10,
        FMT_RSVD = 2'b11
    } nb_fmt_e;

    localparam int NB_FMT_N  = 3;
    localparam int NB_MAX_W  = 32;

    // Operand width of format index idx.
    function automatic int nb_width(input int idx);
        case (idx)
            0:       return 16;
            1:       return 16;
            default: return 32;
        endcase
    endfunction

    // Canonical quiet NaN of format index idx, right-aligned.
    function automatic logic [NB_MAX_W-1:0] nb_qnan(input int idx);
        case (idx)
            0:       return 32'h0000_7fc0;
            1:       return 32'h0000_7e00;
            default: return 32'h7fc0_0000;
        endcase
    endfunction

endpackage

// File: rtl/nanbox_unbox.sv
// Module: read-side checker for one format. Reports a fault when any
// register bit above OP_W is zero, and then substitutes QNAN for the
// operand. Assumes OP_W <= REG_W. When the widths are equal, no check
// is made.
module nanbox_unbox #(
    parameter int REG_W = 64,
    parameter int OP_W  = 16,
    parameter logic [OP_W-1:0] QNAN = '0
) (
    input  logic [REG_W-1:0] reg_val,
    output logic [OP_W-1:0]  operand,
    output logic             fault
);

    generate
        if (OP_W < REG_W) begin : g_check
            localparam int UP_W = REG_W - OP_W;
            logic [UP_W-1:0] upper;
            assign upper = reg_val[REG_W-1:OP_W];

            // Purpose: flag a missing box and pick the operand or the NaN.
            always_comb begin
                fault   = ~(&upper);
                operand = fault ? QNAN : reg_val[OP_W-1:0];
            end

            // Purpose: a substituted operand must be a quiet NaN (exponent all ones).
            always_comb begin
                if (fault) begin
                    a_r4_subst_is_nan: assert (operand[OP_W-2] == 1'b1)
                        else $error("substituted operand lacks NaN exponent");
                end
            end
        end else begin : g_pass
            // Purpose: equal widths leave nothing to check.
            always_comb begin
                fault   = 1'b0;
                operand = reg_val[OP_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/nanbox_box.sv
// Module: write-side boxing for one format. Places the OP_W-bit result
// in the low bits and sets all higher register bits to one. Assumes
// OP_W <= REG_W.
module nanbox_box #(
    parameter int REG_W = 64,
    parameter int OP_W  = 16
) (
    input  logic [OP_W-1:0]  result,
    output logic [REG_W-1:0] reg_val
);

    generate
        if (OP_W < REG_W) begin : g_fill
            // Purpose: pad the upper field with ones.
            always_comb reg_val = {{(REG_W-OP_W){1'b1}}, result};
        end else begin : g_same
            // Purpose: equal widths copy the result as is.
            always_comb reg_val = result;
        end
    endgenerate

endmodule

// File: rtl/nanbox_checker.sv
// Module: top of the NaN-box checker. Builds one read checker and one
// boxer per format and selects between them by the 2-bit format code.
// Code 2'b11 passes data through. Assumes REG_W >= 32. Fully
// combinational.
module nanbox_checker
    import nanbox_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0]    rd_reg,
    input  logic [1:0]          rd_fmt,
    output logic [REG_W-1:0]    rd_operand,
    output logic                rd_box_fault,
    input  logic [1:0]          wr_fmt,
    input  logic [NB_MAX_W-1:0] wr_result,
    output logic [REG_W-1:0]    wr_reg
);

    logic [REG_W-1:0] lane_op    [NB_FMT_N];
    logic             lane_fault [NB_FMT_N];
    logic [REG_W-1:0] lane_wr    [NB_FMT_N];

    generate
        for (genvar k = 0; k < NB_FMT_N; k++) begin : g_fmt
            localparam int LW = nb_width(k);
            localparam logic [NB_MAX_W-1:0] LQ_FULL = nb_qnan(k);
            localparam logic [LW-1:0] LQ = LQ_FULL[LW-1:0];
            logic [LW-1:0] op_narrow;

            nanbox_unbox #(.REG_W(REG_W), .OP_W(LW), .QNAN(LQ)) u_unbox (
                .reg_val (rd_reg),
                .operand (op_narrow),
                .fault   (lane_fault[k])
            );

            nanbox_box #(.REG_W(REG_W), .OP_W(LW)) u_box (
                .result  (wr_result[LW-1:0]),
                .reg_val (lane_wr[k])
            );

            // Purpose: zero-extend this lane's operand to register width.
            always_comb lane_op[k] = REG_W'(op_narrow);
        end
    endgenerate

    // Purpose: select the read result by format; reserved passes through.
    always_comb begin
        case (nb_fmt_e'(rd_fmt))
            FMT_BF16: begin rd_operand = lane_op[0]; rd_box_fault = lane_fault[0]; end
            FMT_FP16: begin rd_operand = lane_op[1]; rd_box_fault = lane_fault[1]; end
            FMT_FP32: begin rd_operand = lane_op[2]; rd_box_fault = lane_fault[2]; end
            default:  begin rd_operand = rd_reg;     rd_box_fault = 1'b0;          end
        endcase
    end

    // Purpose: select the boxed write value by format; reserved zero-extends.
    always_comb begin
        case (nb_fmt_e'(wr_fmt))
            FMT_BF16: wr_reg = lane_wr[0];
            FMT_FP16: wr_reg = lane_wr[1];
            FMT_FP32: wr_reg = lane_wr[2];
            default:  wr_reg = REG_W'(wr_result);
        endcase
    end

    // Purpose: guard read and write outputs against their requirements.
    always_comb begin
        if (rd_fmt == FMT_RSVD) begin
            a_r9_rsvd_no_fault: assert (!rd_box_fault && rd_operand == rd_reg)
                else $error("reserved read altered data");
        end
        if (!rd_box_fault && rd_fmt != FMT_RSVD && REG_W > 32) begin
            a_r3_upper_clear: assert (rd_operand[REG_W-1:NB_MAX_W] == '0)
                else $error("boxed operand has nonzero upper bits");
        end
        if (wr_fmt != FMT_RSVD && REG_W > 32) begin
            a_r1_upper_ones: assert (&wr_reg[REG_W-1:NB_MAX_W])
                else $error("boxed write lacks upper ones");
        end
        if (wr_fmt == FMT_BF16 || wr_fmt == FMT_FP16) begin
            a_r1_low_kept: assert (wr_reg[15:0] == wr_result[15:0] && (&wr_reg[REG_W-1:16]))
                else $error("16-bit boxing wrong");
        end
    end

endmodule

// File: tb/tb_nanbox_checker.sv
module tb_nanbox_checker;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Device with a 64-bit register.
    logic [63:0] rd_reg, rd_operand, wr_reg;
    logic [1:0]  rd_fmt, wr_fmt;
    logic [31:0] wr_result;
    logic        rd_box_fault;

    nanbox_checker #(.REG_W(64)) dut (
        .rd_reg(rd_reg), .rd_fmt(rd_fmt), .rd_operand(rd_operand),
        .rd_box_fault(rd_box_fault), .wr_fmt(wr_fmt),
        .wr_result(wr_result), .wr_reg(wr_reg)
    );

    // Device with a 32-bit register (R11).
    logic [31:0] s_rd_reg, s_rd_operand, s_wr_reg, s_wr_result;
    logic [1:0]  s_rd_fmt, s_wr_fmt;
    logic        s_fault;

    nanbox_checker #(.REG_W(32)) dut32 (
        .rd_reg(s_rd_reg), .rd_fmt(s_rd_fmt), .rd_operand(s_rd_operand),
        .rd_box_fault(s_fault), .wr_fmt(s_wr_fmt),
        .wr_result(s_wr_result), .wr_reg(s_wr_reg)
    );

    localparam int NV = 12;
    localparam logic [63:0] V_REG [NV] = '{
        64'hFFFF_FFFF_FFFF_3F80, 64'hFFFF_FFFF_0000_3F80,
        64'hFFFF_FFFF_FFFF_3C00, 64'h7FFF_FFFF_FFFF_3C00,
        64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFE_3F80_0000,
        64'hFFFF_FFFF_FFFE_1234, 64'hFFFF_FFFF_FFFF_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_7FC0_0001
    };
    localparam logic [1:0] V_FMT [NV] = '{
        2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10,
        2'b00, 2'b00, 2'b01, 2'b11, 2'b10, 2'b00
    };
    localparam logic [63:0] V_OP [NV] = '{
        64'h3F80, 64'h7FC0, 64'h3C00, 64'h7E00,
        64'h3F80_0000, 64'h7FC0_0000, 64'h7FC0, 64'h0000,
        64'hFFFF, 64'h0123_4567_89AB_CDEF, 64'h7FC0_0000, 64'h7FC0
    };
    localparam logic V_FLT [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1,
        1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1
    };
    localparam string V_TAG [NV] = '{
        "R3", "R4", "R3", "R5 R7", "R3", "R6 R7",
        "R7 R4", "R8", "R8", "R9", "R6", "R7"
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd64(input logic [63:0] r, input logic [1:0] f);
        @(posedge clk);
        rd_reg = r; rd_fmt = f;
        @(negedge clk);
    endtask

    task automatic wr64(input logic [31:0] v, input logic [1:0] f);
        @(posedge clk);
        wr_result = v; wr_fmt = f;
        @(negedge clk);
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rd_reg = '0; rd_fmt = 2'b00; wr_result = '0; wr_fmt = 2'b00;
        s_rd_reg = '0; s_rd_fmt = 2'b10; s_wr_result = '0; s_wr_fmt = 2'b10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Initial state with all-zero inputs.
        check("R4 initial read", {rd_operand[62:0], rd_box_fault}, {63'h7FC0, 1'b1});
        check("R1 initial write", wr_reg, 64'hFFFF_FFFF_FFFF_0000);

        // Vector table for the read path.
        for (int i = 0; i < NV; i++) begin
            rd64(V_REG[i], V_FMT[i]);
            check(V_TAG[i], rd_operand, V_OP[i]);
            check({V_TAG[i], " fault"}, {63'h0, rd_box_fault}, {63'h0, V_FLT[i]});
        end

        // Write path.
        wr64(32'hABCD_1234, 2'b00);
        check("R1 bf16 write", wr_reg, 64'hFFFF_FFFF_FFFF_1234);
        wr64(32'h0000_3C00, 2'b01);
        check("R1 fp16 write", wr_reg, 64'hFFFF_FFFF_FFFF_3C00);
        wr64(32'h4049_0FDB, 2'b10);
        check("R2 fp32 write", wr_reg, 64'hFFFF_FFFF_4049_0FDB);
        wr64(32'h8000_0001, 2'b11);
        check("R9 rsvd write", wr_reg, 64'h0000_0000_8000_0001);

        // Round trip: feed the boxed value back into the read side.
        for (int f = 0; f < 3; f++) begin
            wr64(32'h5A5A_C3E1, 2'(f));
            rd64(wr_reg, 2'(f));
            check("R10 round trip", {rd_operand[62:0], rd_box_fault},
                  {(f == 2 ? 63'h5A5A_C3E1 : 63'hC3E1), 1'b0});
        end

        // 32-bit register instance: single precision unchecked.
        @(posedge clk);
        s_rd_reg = 32'h0000_0001; s_rd_fmt = 2'b10;
        s_wr_result = 32'h1234_5678; s_wr_fmt = 2'b10;
        @(negedge clk);
        check("R11 fp32 read", {31'h0, s_rd_operand, s_fault}, {31'h0, 32'h0000_0001, 1'b0});
        check("R11 fp32 write", {32'h0, s_wr_reg}, {32'h0, 32'h1234_5678});
        @(posedge clk);
        s_rd_reg = 32'h0000_3F80; s_rd_fmt = 2'b00; s_wr_fmt = 2'b00;
        @(negedge clk);
        check("R4 narrow reg read", {31'h0, s_rd_operand, s_fault}, {31'h0, 32'h7FC0, 1'b1});
        check("R1 narrow reg write", {32'h0, s_wr_reg}, {32'h0, 32'hFFFF_5678});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule